// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Status Controller

This block gathers interrupt events from two sources and reports them to a host. One source is bus-side and has two status words. The other is DMA-side and has one status word. Each status word is read-to-clear. A summary register holds one pending flag per source. An active-low request line, `irq_n`, signals the host. The host reads the summary to find the source, then reads that source's status words to collect and clear the bits.

While any pending flag is set, new events do not disturb the words the host is servicing. They are collected in a hidden second level. When the host's reads leave no pending flag and the hidden level holds bits, the request line is forced high for a programmable gap. The hidden bits are then merged into the visible words, and the request asserts again if any of the merged bits may drive it.

Each status bit has a mask bit. Each bit also has a fatal or nonfatal class, fixed by a parameter. A global disable bit blocks new assertions of the request line. It lets an assertion already in progress run until the host services it.

Top module: `stacked_irq_ctrl`

## Requirements
- R1: After reset, all status words, hidden bits, masks and the disable bit read as zero, and `irq_n` is high.
- R2: A read of a status word returns its contents in the same cycle and clears them. The word addresses are 1 (bus word A), 2 (bus word B) and 3 (DMA word). A following read returns zero.
- R3: An unmasked event that arrives while no pending flag is set goes into the visible word and sets its source's pending flag. The summary at address 0 shows bit 0 for the bus source and bit 1 for the DMA source. `irq_n` goes low after the next clock edge.
- R4: While any pending flag is set, new events go to the hidden level. Reads of the visible words do not show them.
- R5: Further events that arrive while the hidden level is already occupied are ORed into it. None is lost.
- R6: When a clearing read leaves no pending flag and the hidden level is not empty, `irq_n` stays high for exactly GAP_CYC cycles (default 3). The hidden bits are then merged into the visible words.
- R7: A masked nonfatal event still sets its status bit, but it sets no pending flag and does not drive `irq_n`. Events that follow it go straight to the visible words. Mask registers are at addresses 4, 5 and 6, and a mask bit of 1 masks that bit.
- R8: A masked fatal event sets its pending flag but does not drive `irq_n`. The default fatal bits are bit 0 of bus word A, bit 7 of bus word B, and bits 0 and 1 of the DMA word.
- R9: Writing a mask while `irq_n` is low does not release `irq_n`, and the pending flag remains set.
- R10: Setting the disable bit (address 7, bit 0) while `irq_n` is low keeps it low until serviced. After that, `irq_n` stays high until the bit is cleared, and it asserts once the bit is cleared if request bits remain.
- R11: The pending flags in the summary report interrupts while the disable bit or a mask keeps `irq_n` high.
- R12: An event that arrives in the same cycle as the clearing read is captured in the set that is promoted after the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_evt0 | input | W | Event pulses for bus word A |
| bus_evt1 | input | W | Event pulses for bus word B |
| dma_evt | input | W | Event pulses for the DMA word |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data, valid in the cycle of the strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Single events on an idle block check direct posting: the status bit lands in the visible word, the pending flag sets and `irq_n` asserts. Bursts of events while a flag is pending, some repeated on the same word, separate stacking from direct posting and show that ORing loses nothing. Masked nonfatal bits followed by unmasked ones tell the no-stacking rule apart from ordinary stacking, and masked fatal bits show a pending flag raised without a request. Disable and mask writes made while the line is low, and reads that race a new event, test the hold, block and capture rules. The width of each gap is measured from `irq_n` itself.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int NUM_WORDS = 3;

  typedef enum logic [2:0] {
    ADR_SUMMARY = 3'd0,
    ADR_BUS_A   = 3'd1,
    ADR_BUS_B   = 3'd2,
    ADR_DMA     = 3'd3,
    ADR_MSK_A   = 3'd4,
    ADR_MSK_B   = 3'd5,
    ADR_MSK_DMA = 3'd6,
    ADR_CTRL    = 3'd7
  } sic_addr_e;

endpackage

// File: rtl/sic_word.sv
// One status word with its visible and hidden levels.
// Per level: raw status bits, bits that raise the pending flag,
// and bits that may drive the request line.
module sic_word #(
  parameter int             W     = 8,
  parameter logic [W-1:0]   FATAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] mask,
  input  logic         to_shadow,
  input  logic         promote,
  input  logic         rd_clr,
  output logic [W-1:0] vis,
  output logic         pend,
  output logic         pend_nxt,
  output logic         req_nxt,
  output logic         sh_any,
  output logic         sh_nxt_any
);

  logic [W-1:0] vis_q, vp_q, vi_q, sh_q, sp_q, si_q;
  logic [W-1:0] vis_d, vp_d, vi_d, sh_d, sp_d, si_d;
  logic [W-1:0] q_pend, q_req, keep;
  logic         en;

  assign q_pend = evt & (~mask | FATAL);
  assign q_req  = evt & ~mask;
  assign keep   = rd_clr ? '0 : '1;
  assign en     = rd_clr | promote | (|evt);

  always_comb begin
    vis_d = vis_q & keep;
    vp_d  = vp_q & keep;
    vi_d  = vi_q & keep;
    sh_d  = sh_q;
    sp_d  = sp_q;
    si_d  = si_q;
    if (promote) begin
      vis_d = vis_d | sh_q | evt;
      vp_d  = vp_d | sp_q | q_pend;
      vi_d  = vi_d | si_q | q_req;
      sh_d  = '0;
      sp_d  = '0;
      si_d  = '0;
    end else if (to_shadow) begin
      sh_d  = sh_q | evt;
      sp_d  = sp_q | q_pend;
      si_d  = si_q | q_req;
    end else begin
      vis_d = vis_d | evt;
      vp_d  = vp_d | q_pend;
      vi_d  = vi_d | q_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q <= '0;
      vp_q  <= '0;
      vi_q  <= '0;
      sh_q  <= '0;
      sp_q  <= '0;
      si_q  <= '0;
    end else if (en) begin
      vis_q <= vis_d;
      vp_q  <= vp_d;
      vi_q  <= vi_d;
      sh_q  <= sh_d;
      sp_q  <= sp_d;
      si_q  <= si_d;
    end
  end

  assign vis        = vis_q;
  assign pend       = |vp_q;
  assign pend_nxt   = |vp_d;
  assign req_nxt    = |vi_d;
  assign sh_any     = |sh_q;
  assign sh_nxt_any = |sh_d;

endmodule

// File: rtl/sic_gap.sv
// Forced request gap before promotion of the hidden level.
module sic_gap #(
  parameter int GAP_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic busy_nxt,
  output logic promote
);

  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start)           cnt_d = GW'(GAP_CYC);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy     = (cnt_q != 0);
  assign busy_nxt = (cnt_d != 0);
  assign promote  = (cnt_q == GW'(1));

endmodule

// File: rtl/stacked_irq_ctrl.sv
module stacked_irq_ctrl
  import sic_pkg::*;
#(
  parameter int               W         = 8,
  parameter int               GAP_CYC   = 3,
  parameter logic [3*W-1:0]   FATAL_MAP = 24'h03_80_01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_evt0,
  input  logic [W-1:0] bus_evt1,
  input  logic [W-1:0] dma_evt,
  input  logic         reg_rd,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq_n
);

  logic [W-1:0] evt_w  [NUM_WORDS];
  logic [W-1:0] vis_w  [NUM_WORDS];
  logic [W-1:0] mask_q [NUM_WORDS];
  logic [W-1:0] mask_d [NUM_WORDS];
  logic [NUM_WORDS-1:0] pend_w, pend_nxt_w, req_nxt_w, sh_w, sh_nxt_w;

  logic bus_pend, dma_pend, pend_any, pend_any_nxt, sh_any, sh_nxt_any;
  logic gap_busy, gap_busy_nxt, promote, gap_start, to_shadow, evt_any;
  logic dis_q, dis_d, irq_on_q, irq_on_d;

  assign evt_w[0] = bus_evt0;
  assign evt_w[1] = bus_evt1;
  assign evt_w[2] = dma_evt;
  assign evt_any  = |{bus_evt0, bus_evt1, dma_evt};

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic rd_clr;
    assign rd_clr = reg_rd && (reg_addr == 3'(ADR_BUS_A + g));

    sic_word #(
      .W     (W),
      .FATAL (FATAL_MAP[g*W +: W])
    ) u_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt_w[g]),
      .mask       (mask_q[g]),
      .to_shadow  (to_shadow),
      .promote    (promote),
      .rd_clr     (rd_clr),
      .vis        (vis_w[g]),
      .pend       (pend_w[g]),
      .pend_nxt   (pend_nxt_w[g]),
      .req_nxt    (req_nxt_w[g]),
      .sh_any     (sh_w[g]),
      .sh_nxt_any (sh_nxt_w[g])
    );

    always_comb begin
      mask_d[g] = mask_q[g];
      if (reg_wr && (reg_addr == 3'(ADR_MSK_A + g))) mask_d[g] = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[g] <= '0;
      else        mask_q[g] <= mask_d[g];
    end
  end

  assign bus_pend     = pend_w[0] | pend_w[1];
  assign dma_pend     = pend_w[2];
  assign pend_any     = |pend_w;
  assign pend_any_nxt = |pend_nxt_w;
  assign sh_any       = |sh_w;
  assign sh_nxt_any   = |sh_nxt_w;

  // Events are held back while a first level is pending or a gap runs.
  assign to_shadow = (pend_any | gap_busy) & ~promote;
  assign gap_start = pend_any & ~pend_any_nxt & sh_nxt_any & ~gap_busy;

  sic_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (gap_start),
    .busy     (gap_busy),
    .busy_nxt (gap_busy_nxt),
    .promote  (promote)
  );

  always_comb begin
    dis_d = dis_q;
    if (reg_wr && (reg_addr == ADR_CTRL)) dis_d = reg_wdata[0];
    irq_on_d = (|req_nxt_w) & ~gap_busy_nxt & (~dis_d | irq_on_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q    <= 1'b0;
      irq_on_q <= 1'b0;
    end else begin
      dis_q    <= dis_d;
      irq_on_q <= irq_on_d;
    end
  end

  assign irq_n = ~irq_on_q;

  always_comb begin
    case (reg_addr)
      ADR_SUMMARY: reg_rdata = {{(W-2){1'b0}}, dma_pend, bus_pend};
      ADR_BUS_A:   reg_rdata = vis_w[0];
      ADR_BUS_B:   reg_rdata = vis_w[1];
      ADR_DMA:     reg_rdata = vis_w[2];
      ADR_MSK_A:   reg_rdata = mask_q[0];
      ADR_MSK_B:   reg_rdata = mask_q[1];
      ADR_MSK_DMA: reg_rdata = mask_q[2];
      default:     reg_rdata = {{(W-1){1'b0}}, dis_q};
    endcase
  end

endmodule

// File: rtl/sic_checker.sv
module sic_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_n,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic       evt_any,
  input logic       pend_any,
  input logic       gap_busy,
  input logic       promote,
  input logic       sh_any,
  input logic       dis_q
);

  // R3: an asserted request always has a pending flag behind it
  assert_irq_has_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> pend_any);

  // R4: events during a pending first level land in the hidden level
  assert_stack_to_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_any && !promote && evt_any) |=> sh_any);

  // R6: the request line is high throughout the gap
  assert_gap_keeps_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |-> irq_n);

  // R6: promotion ends the gap
  assert_gap_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    promote |=> !gap_busy);

  // R9: mask writes never release an asserted request
  assert_mask_no_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && reg_wr && !reg_rd && (reg_addr >= 3'd4) && (reg_addr <= 3'd6)) |=> !irq_n);

  // R10: a blocked request stays high while the disable bit holds
  assert_disable_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && irq_n && !(reg_wr && reg_addr == 3'd7)) |=> irq_n);

endmodule

bind stacked_irq_ctrl sic_checker u_sic_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_n    (irq_n),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .evt_any  (evt_any),
  .pend_any (pend_any),
  .gap_busy (gap_busy),
  .promote  (promote),
  .sh_any   (sh_any),
  .dis_q    (dis_q)
);

// File: tb/test_stacked_irq_ctrl.sv
module test_stacked_irq_ctrl;

  localparam int GAP = 3;
  localparam logic [7:0] FAT [3] = '{8'h01, 8'h80, 8'h03};

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_evt0, bus_evt1, dma_evt, reg_wdata, reg_rdata;
  logic       reg_rd, reg_wr, irq_n;
  logic [2:0] reg_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int hrun = 0;
  int last_run = 0;

  // reference model state
  logic [7:0] mv[3], mp[3], mi[3], ms[3], msp[3], msi[3], mm[3];
  bit mdis, mon;
  int mgap;

  always #5 clk = ~clk;

  stacked_irq_ctrl i_stacked_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_evt0(bus_evt0), .bus_evt1(bus_evt1),
    .dma_evt(dma_evt), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return {6'b0, |mp[2], |(mp[0] | mp[1])};
      3'd1, 3'd2, 3'd3: return mv[a-1];
      3'd4, 3'd5, 3'd6: return mm[a-4];
      default: return {7'b0, mdis};
    endcase
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      mv[k] = 0; mp[k] = 0; mi[k] = 0; ms[k] = 0; msp[k] = 0; msi[k] = 0; mm[k] = 0;
    end
    mdis = 0; mon = 0; mgap = 0;
  endtask

  task automatic model_step(input logic [7:0] e[3], input bit rd, input bit wr,
                            input logic [2:0] a, input logic [7:0] wd);
    bit pend_now, pend_nx, sh_nx, prom, busy, stk, req;
    logic [7:0] qp, qi;
    pend_now = 0; pend_nx = 0; sh_nx = 0; req = 0;
    for (int k = 0; k < 3; k++) pend_now |= (mp[k] != 0);
    prom = (mgap == 1);
    busy = (mgap != 0);
    stk  = (pend_now || busy) && !prom;
    for (int k = 0; k < 3; k++) begin
      qp = e[k] & (~mm[k] | FAT[k]);
      qi = e[k] & ~mm[k];
      if (rd && a == 3'(k + 1)) begin mv[k] = 0; mp[k] = 0; mi[k] = 0; end
      if (prom) begin
        mv[k] |= ms[k] | e[k]; mp[k] |= msp[k] | qp; mi[k] |= msi[k] | qi;
        ms[k] = 0; msp[k] = 0; msi[k] = 0;
      end else if (stk) begin
        ms[k] |= e[k]; msp[k] |= qp; msi[k] |= qi;
      end else begin
        mv[k] |= e[k]; mp[k] |= qp; mi[k] |= qi;
      end
      pend_nx |= (mp[k] != 0);
      sh_nx   |= (ms[k] != 0);
      req     |= (mi[k] != 0);
    end
    if (pend_now && !pend_nx && sh_nx && !busy) mgap = GAP;
    else if (mgap != 0) mgap--;
    if (wr && a >= 3'd4 && a <= 3'd6) mm[a-4] = wd;
    if (wr && a == 3'd7) mdis = wd[0];
    mon = req && (mgap == 0) && (!mdis || mon);
  endtask

  // One bus cycle, entered just after a falling edge.
  task automatic cyc(input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] ed,
                     input bit rd, input bit wr, input logic [2:0] a,
                     input logic [7:0] wd, output logic [7:0] rv);
    logic [7:0] ev[3];
    bus_evt0 = e0; bus_evt1 = e1; dma_evt = ed;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    rv = reg_rdata;
    chk("R3/R6/R9/R10 irq_n", {7'b0, irq_n}, {7'b0, !mon});
    if (rd) chk("R2/R4/R5 rdata", reg_rdata, model_rd(a));
    if (irq_n) hrun++;
    else begin if (hrun > 0) last_run = hrun; hrun = 0; end
    ev[0] = e0; ev[1] = e1; ev[2] = ed;
    model_step(ev, rd, wr, a, wd);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    logic [7:0] v;
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, v);
  endtask

  task automatic ev(input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] ed);
    logic [7:0] v;
    cyc(e0, e1, ed, 0, 0, 0, 0, v);
  endtask

  task automatic rdr(input logic [2:0] a, output logic [7:0] v);
    cyc(0, 0, 0, 1, 0, a, 0, v);
  endtask

  task automatic wrr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] v;
    cyc(0, 0, 0, 0, 1, a, d, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 0; bus_evt0 = 0; bus_evt1 = 0; dma_evt = 0;
    reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    rdr(0, v); chk("R1 summary", v, 8'h00);
    rdr(4, v); chk("R1 mask", v, 8'h00);
    rdr(7, v); chk("R1 ctrl", v, 8'h00);
    rdr(3, v); chk("R1 dma word", v, 8'h00);

    // R3: direct posting
    ev(8'h04, 0, 0);
    rdr(0, v); chk("R3 summary bus", v, 8'h01);
    chk("R3 irq low", {7'b0, irq_n}, 8'h00);

    // R4/R5: stacking while pending, then R6 promotion
    ev(0, 0, 8'h10);
    ev(0, 8'h20, 0);
    ev(0, 0, 8'h08);
    rdr(3, v); chk("R4 dma hidden", v, 8'h00);
    rdr(2, v); chk("R4 busB hidden", v, 8'h00);
    rdr(1, v); chk("R2 busA read", v, 8'h04);
    idle(4);
    chk("R6 gap width", 8'(last_run), 8'(GAP));
    rdr(3, v); chk("R5 dma merged", v, 8'h18);
    rdr(2, v); chk("R5 busB promoted", v, 8'h20);
    rdr(2, v); chk("R2 cleared", v, 8'h00);

    // R12: event in the clearing read cycle
    idle(2);
    ev(8'h01, 0, 0);
    cyc(0, 0, 8'h40, 1, 0, 3'd1, 0, v); chk("R12 read value", v, 8'h01);
    idle(4);
    chk("R12 gap width", 8'(last_run), 8'(GAP));
    rdr(3, v); chk("R12 captured", v, 8'h40);

    // R7: masked nonfatal posts without pending
    wrr(4, 8'hFE);
    ev(8'h02, 0, 0);
    rdr(0, v); chk("R7 no pending", v, 8'h00);
    chk("R7 irq high", {7'b0, irq_n}, 8'h01);
    ev(0, 0, 8'h04);
    rdr(3, v); chk("R7 not stacked", v, 8'h04);
    rdr(1, v); chk("R7 status set", v, 8'h02);

    // R8/R11: masked fatal raises pending, not the request
    wrr(4, 8'hFF);
    ev(8'h01, 0, 0);
    rdr(0, v); chk("R8 pending", v, 8'h01);
    chk("R8 irq high", {7'b0, irq_n}, 8'h01);
    ev(0, 0, 8'h02);
    rdr(3, v); chk("R8 stacked", v, 8'h00);
    rdr(1, v); chk("R8 busA", v, 8'h01);
    idle(4);
    chk("R8 irq after promote", {7'b0, irq_n}, 8'h00);
    rdr(3, v); chk("R8 promoted", v, 8'h02);
    wrr(4, 8'h00);

    // R9: mask after assertion
    ev(0, 8'h10, 0);
    wrr(5, 8'hFF);
    wrr(6, 8'hFF);
    chk("R9 irq held", {7'b0, irq_n}, 8'h00);
    rdr(0, v); chk("R9 pending kept", v, 8'h01);
    rdr(2, v); chk("R9 busB", v, 8'h10);
    wrr(5, 8'h00);
    wrr(6, 8'h00);

    // R10/R11: global disable
    ev(0, 0, 8'h01);
    wrr(7, 8'h01);
    idle(1);
    chk("R10 held", {7'b0, irq_n}, 8'h00);
    rdr(3, v); chk("R10 dma", v, 8'h01);
    ev(8'h08, 0, 0);
    idle(2);
    chk("R10 blocked", {7'b0, irq_n}, 8'h01);
    rdr(0, v); chk("R11 poll", v, 8'h01);
    wrr(7, 8'h00);
    chk("R10 released", {7'b0, irq_n}, 8'h00);
    rdr(1, v); chk("R10 busA", v, 8'h08);
    idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule